// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of 32 general-purpose pins behind a word-wide register port. Software chooses each pin's direction, drives an output latch that can be written whole or changed bit by bit through separate set and clear ports, and reads back pin levels after a two-stage synchronizer. The bank watches every pin for a rising edge, a falling edge, a high level or a low level, each selected by its own per-pin enable.

Detected events are latched as pending bits. There is one pending register for each of two interrupt lines. Each line has its own enable mask, which is changed only through write-one-to-set and write-one-to-clear ports. Pending bits are cleared by writing ones. Each interrupt output is the OR of its line's pending bits that are enabled.

The register port is a single-cycle strobe interface. A write takes effect on the next clock edge. Read data is combinational from the address while the read strobe is high.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register (0x134) reads all ones and `drive_en_o` is all zeros. The output latch, every detect enable, every line enable and every pending bit read zero, and `irq_o` is zero.
- R2: Address 0x000 always reads 0x50600801. Writes to it change nothing.
- R3: Bit n of the direction register (0x134) set to 1 makes pin n an input (`drive_en_o[n]`=0). Set to 0, it drives (`drive_en_o[n]`=1). `pin_o` always shows the output latch.
- R4: The output latch is read and written at 0x13C. A write to 0x194 sets the latch bits written as 1, a write to 0x190 clears them, and bits written as 0 stay as they were.
- R5: Address 0x138 returns the pin inputs through two synchronizer flops. A change on `pin_i` is not visible in the first cycle after the capturing edge and is visible from the second.
- R6: With bit n of the rising-edge enable (0x148) set, a 0-to-1 transition of synchronized pin n sets pending bit n on every line.
- R7: With bit n of the falling-edge enable (0x14C) set, a 1-to-0 transition sets pending bit n. With both edge enables set, either edge sets it. An edge whose enable is clear sets nothing.
- R8: The high-level enable (0x144) and the low-level enable (0x140) set pending bit n in every cycle the selected level is present. A clear written while the level persists therefore leaves the bit pending.
- R9: The raw pending register of line k (0x024 + 4k) captures events whatever the line's enable. The status register of line k (0x02C + 4k) reads raw pending ANDed with the line's enable mask.
- R10: For line k, a write to 0x034 + 4k sets the enable bits written as 1, and a write to 0x03C + 4k clears them. Zero bits change nothing, and both addresses read the current mask.
- R11: Writing 1 to a bit of status register 0x02C + 4k clears that raw pending bit of line k only. Writing 0 has no effect. A new event on the same bit in the same cycle keeps the bit set.
- R12: `irq_o[k]` is high exactly when line k has an enabled pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; read data is valid while it is high |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not reading or when the address is unmapped |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Output latch value to the pads |
| drive_en_o | output | 32 | Per-pin drive enable, 1 = pin is driven |
| irq_o | output | 2 | Interrupt line outputs |

## Verification
The bench builds the bank with its default 32 pins and 2 interrupt lines. This lets one test pin step through edge, level and mask cases while the other line's pending register is checked to stay independent. Using both lines exposes the per-line address offsets and the cross-line effects of clears and enables, such as an event raised on a line whose mask is off. The full 32-bit width places stimulus in the top half-word and the top byte, so a truncated latch or a wrong direction polarity shows at the pins.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_REV   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h134;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 12'h138;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 12'h13C;
  localparam logic [ADDR_W-1:0] OFS_LVLLO = 12'h140;
  localparam logic [ADDR_W-1:0] OFS_LVLHI = 12'h144;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 12'h148;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 12'h14C;
  localparam logic [ADDR_W-1:0] OFS_DCLR  = 12'h190;
  localparam logic [ADDR_W-1:0] OFS_DSET  = 12'h194;

  localparam logic [31:0] REV_ID = 32'h5060_0801;

  // per-line registers sit one word apart
  function automatic logic [ADDR_W-1:0] line_ofs(input logic [ADDR_W-1:0] base,
                                                 input int unsigned k);
    return base + ADDR_W'(4 * k);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] hi_en_i,
  input  logic [W-1:0] lo_en_i,
  output logic [W-1:0] trig_o
);
  logic [W-1:0] rose, fell;

  assign rose   = cur_i & ~prev_i;
  assign fell   = ~cur_i & prev_i;
  assign trig_o = (rose & rise_en_i) | (fell & fall_en_i) |
                  (cur_i & hi_en_i) | (~cur_i & lo_en_i);
endmodule

// File: rtl/gpio_irq_line.sv
`timescale 1ns/1ps
module gpio_irq_line #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] trig_i,
  input  logic         en_set_i,
  input  logic         en_clr_i,
  input  logic         st_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, en_q, set_m, clr_m, ack_m;

  assign set_m = en_set_i ? wdata_i : '0;
  assign clr_m = en_clr_i ? wdata_i : '0;
  assign ack_m = st_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      en_q  <= (en_q | set_m) & ~clr_m;
      // a new event overrides a same-cycle acknowledge
      raw_q <= (raw_q & ~ack_m) | trig_i;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = |(raw_q & en_q);
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned NUM_LINES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PINS-1:0]  wdata_i,
  output logic [NUM_PINS-1:0]  rdata_o,
  input  logic [NUM_PINS-1:0]  pin_i,
  output logic [NUM_PINS-1:0]  pin_o,
  output logic [NUM_PINS-1:0]  drive_en_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam logic [NUM_PINS-1:0] REV_VAL = NUM_PINS'(REV_ID);

  logic [NUM_PINS-1:0] dir_q, dout_q, lo_en_q, hi_en_q, rise_en_q, fall_en_q;
  logic [NUM_PINS-1:0] pin_cur, pin_prev, trig;
  logic [NUM_LINES-1:0][NUM_PINS-1:0] line_raw, line_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '1;
      dout_q    <= '0;
      lo_en_q   <= '0;
      hi_en_q   <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_DIR:   dir_q     <= wdata_i;
        OFS_DOUT:  dout_q    <= wdata_i;
        OFS_DSET:  dout_q    <= dout_q | wdata_i;
        OFS_DCLR:  dout_q    <= dout_q & ~wdata_i;
        OFS_LVLLO: lo_en_q   <= wdata_i;
        OFS_LVLHI: hi_en_q   <= wdata_i;
        OFS_RISE:  rise_en_q <= wdata_i;
        OFS_FALL:  fall_en_q <= wdata_i;
        default: ;
      endcase
    end
  end

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  gpio_irq_detect #(.W(NUM_PINS)) u_detect (
    .cur_i     (pin_cur),
    .prev_i    (pin_prev),
    .rise_en_i (rise_en_q),
    .fall_en_i (fall_en_q),
    .hi_en_i   (hi_en_q),
    .lo_en_i   (lo_en_q),
    .trig_o    (trig)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    gpio_irq_line #(.W(NUM_PINS)) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (trig),
      .en_set_i (wr_en_i && (addr_i == line_ofs(OFS_ENSET, k))),
      .en_clr_i (wr_en_i && (addr_i == line_ofs(OFS_ENCLR, k))),
      .st_clr_i (wr_en_i && (addr_i == line_ofs(OFS_STAT, k))),
      .wdata_i  (wdata_i),
      .raw_o    (line_raw[k]),
      .en_o     (line_en[k]),
      .irq_o    (irq_o[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFS_REV:   rdata_o = REV_VAL;
        OFS_DIR:   rdata_o = dir_q;
        OFS_DIN:   rdata_o = pin_cur;
        OFS_DOUT:  rdata_o = dout_q;
        OFS_LVLLO: rdata_o = lo_en_q;
        OFS_LVLHI: rdata_o = hi_en_q;
        OFS_RISE:  rdata_o = rise_en_q;
        OFS_FALL:  rdata_o = fall_en_q;
        default: ;
      endcase
      for (int k = 0; k < NUM_LINES; k++) begin
        if (addr_i == line_ofs(OFS_RAW, k))   rdata_o = line_raw[k];
        if (addr_i == line_ofs(OFS_STAT, k))  rdata_o = line_raw[k] & line_en[k];
        if (addr_i == line_ofs(OFS_ENSET, k)) rdata_o = line_en[k];
        if (addr_i == line_ofs(OFS_ENCLR, k)) rdata_o = line_en[k];
      end
    end
  end

  assign pin_o      = dout_q;
  assign drive_en_o = ~dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned NUM_LINES = 2
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               wr_en_i,
  input logic                               rd_en_i,
  input logic [ADDR_W-1:0]                  addr_i,
  input logic [NUM_PINS-1:0]                wdata_i,
  input logic [NUM_PINS-1:0]                rdata_o,
  input logic [NUM_PINS-1:0]                dout_q,
  input logic [NUM_LINES-1:0]               irq_o,
  input logic [NUM_LINES-1:0][NUM_PINS-1:0] line_raw,
  input logic [NUM_LINES-1:0][NUM_PINS-1:0] line_en
);
  // R2
  a_r2_rev_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_REV) |-> (rdata_o == NUM_PINS'(REV_ID)));

  // R4
  a_r4_set_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DSET) |=> ((dout_q & $past(wdata_i)) == $past(wdata_i)));

  a_r4_clr_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DCLR) |=> ((dout_q & $past(wdata_i)) == '0));

  // R10
  a_r10_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == line_ofs(OFS_ENSET, 0))
      |=> ((line_en[0] & $past(wdata_i)) == $past(wdata_i)));

  a_r10_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == line_ofs(OFS_ENCLR, 0))
      |=> ((line_en[0] & $past(wdata_i)) == '0));

  // R11: a zero write to the status port never drops a pending bit
  a_r11_zero_ack_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_STAT && wdata_i == '0)
      |=> ((line_raw[0] & $past(line_raw[0])) == $past(line_raw[0])));

  // R12
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
    a_r12_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_en[k] == '0) |-> !irq_o[k]);
  end
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS  (NUM_PINS),
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .dout_q   (dout_q),
  .irq_o    (irq_o),
  .line_raw (line_raw),
  .line_en  (line_en)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, drv;
  logic [1:0]  irq;

  typedef struct {
    logic [11:0] a;
    logic [31:0] e;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t it;
  int n_cmp = 0, n_bad = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank uut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .rd_en_i (rd_en),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .pin_i (pin_in),
    .pin_o (pin_out), .drive_en_o (drv), .irq_o (irq)
  );

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rd_en && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_cmp++;
      if (rdata !== it.e) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    sb_q.push_back('{a: a, e: e, tag: tag});
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic check_val(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd_exp(12'h134, 32'hFFFF_FFFF, "R1 direction after reset");
    rd_exp(12'h13C, 32'h0, "R1 latch after reset");
    rd_exp(12'h024, 32'h0, "R1 raw0 after reset");
    rd_exp(12'h034, 32'h0, "R1 enable0 after reset");
    rd_exp(12'h148, 32'h0, "R1 rise enable after reset");
    check_val(drv, 32'h0, "R1 drive enables after reset");
    check_val({30'h0, irq}, 32'h0, "R1 irq after reset");

    // R2 revision
    rd_exp(12'h000, 32'h5060_0801, "R2 revision");
    wr(12'h000, 32'h0);
    rd_exp(12'h000, 32'h5060_0801, "R2 revision after write");

    // R4 latch, set and clear ports
    wr(12'h13C, 32'h0000_00F0);
    rd_exp(12'h13C, 32'h0000_00F0, "R4 latch write");
    wr(12'h194, 32'h0F00_0001);
    rd_exp(12'h13C, 32'h0F00_00F1, "R4 set port");
    wr(12'h190, 32'h0000_0030);
    rd_exp(12'h13C, 32'h0F00_00C1, "R4 clear port");
    wr(12'h194, 32'h0);
    rd_exp(12'h13C, 32'h0F00_00C1, "R4 zero set write");

    // R3 direction
    wr(12'h134, 32'hFFFF_0000);
    check_val(drv, 32'h0000_FFFF, "R3 drive enables");
    check_val(pin_out, 32'h0F00_00C1, "R3 pin output");

    // R5 synchronizer latency
    pin_in = 32'hA5A5_0000;
    rd_exp(12'h138, 32'h0, "R5 input not yet visible");
    idle(2);
    rd_exp(12'h138, 32'hA5A5_0000, "R5 input visible");

    pin_in = 32'h0;
    idle(4);

    // R6 rising edge, R9 raw versus status
    wr(12'h148, 32'h1);
    wr(12'h034, 32'h1);
    pin_in = 32'h1;
    idle(4);
    rd_exp(12'h024, 32'h1, "R6 raw0 rising");
    rd_exp(12'h02C, 32'h1, "R9 status0 enabled");
    check_val({30'h0, irq}, 32'h1, "R12 irq line0");
    rd_exp(12'h028, 32'h1, "R9 raw1 set while disabled");
    rd_exp(12'h030, 32'h0, "R9 status1 masked");

    // R11 per-line clear
    wr(12'h02C, 32'h1);
    rd_exp(12'h024, 32'h0, "R11 raw0 cleared");
    rd_exp(12'h028, 32'h1, "R11 raw1 untouched");
    check_val({30'h0, irq}, 32'h0, "R12 irq after clear");
    wr(12'h030, 32'h0);
    rd_exp(12'h028, 32'h1, "R11 zero write no effect");
    wr(12'h030, 32'h1);
    rd_exp(12'h028, 32'h0, "R11 raw1 cleared");

    // R7 falling and both edges
    wr(12'h148, 32'h3);
    wr(12'h14C, 32'h2);
    pin_in = 32'h3;
    idle(4);
    rd_exp(12'h024, 32'h2, "R7 both-edge pin rising");
    wr(12'h02C, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
    pin_in = 32'h0;
    idle(4);
    rd_exp(12'h024, 32'h2, "R7 falling only where enabled");
    wr(12'h02C, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h148, 32'h0);
    wr(12'h14C, 32'h0);

    // R8 level high and low
    pin_in = 32'h10;
    wr(12'h144, 32'h10);
    idle(4);
    rd_exp(12'h024, 32'h10, "R8 high level");
    wr(12'h02C, 32'h10);
    rd_exp(12'h024, 32'h10, "R8 stays pending while high");
    pin_in = 32'h0;
    idle(4);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd_exp(12'h024, 32'h0, "R8 clears once level gone");
    wr(12'h144, 32'h0);
    wr(12'h140, 32'h20);
    idle(2);
    rd_exp(12'h024, 32'h20, "R8 low level");
    pin_in = 32'h20;
    idle(4);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd_exp(12'h024, 32'h0, "R8 low level released");
    wr(12'h140, 32'h0);
    wr(12'h030, 32'hFFFF_FFFF);

    // R10 enable set/clear ports
    wr(12'h034, 32'h30);
    rd_exp(12'h034, 32'h31, "R10 set port");
    rd_exp(12'h03C, 32'h31, "R10 clear port reads mask");
    wr(12'h03C, 32'h1);
    rd_exp(12'h034, 32'h30, "R10 clear port");
    wr(12'h034, 32'h0);
    rd_exp(12'h034, 32'h30, "R10 zero write no effect");
    wr(12'h038, 32'h80);
    rd_exp(12'h038, 32'h80, "R10 line1 mask");
    rd_exp(12'h034, 32'h30, "R10 line0 mask independent");

    // R12 line selection
    pin_in = 32'h0;
    wr(12'h148, 32'h80);
    pin_in = 32'h80;
    idle(4);
    check_val({30'h0, irq}, 32'h2, "R12 only line1 fires");
    rd_exp(12'h02C, 32'h0, "R9 status0 masked");
    rd_exp(12'h030, 32'h80, "R9 status1");
    wr(12'h040, 32'h80);
    check_val({30'h0, irq}, 32'h0, "R12 irq off after mask clear");
    rd_exp(12'h028, 32'h80, "R9 raw1 kept after mask clear");

    idle(2);
    report();
    $finish;
  end
endmodule